// File: doc/BRIEF.md
# USB Host Transmit Priority Multiplexer

This block lets six host-side controllers share one UTMI-style transmit path to a USB PHY. Every controller presents its own transmit byte, its own transmit-valid strobe and an active flag that says it wants the line. On every clock edge the block chooses one owner. A packet already in flight keeps its owner. Otherwise the owner is the highest-priority controller whose active flag is set. The owner's byte and valid go to the PHY, and the PHY's ready comes back to the owner alone.

Source index 0 has the highest priority and index 5 the lowest. The sources are, in index order: bus-reset controller, enumerator, transaction engine, protocol handler, token generator, and start-of-frame generator. The grant is registered. Once the owner has presented transmit-valid on a clock edge, the grant cannot move until the owner lets valid fall. This stops a more urgent source from breaking into the middle of a packet. The current owner is reported both as a one-hot vector and as an encoded index.

Top module: `usb_tx_prio_mux`

## Requirements
- R1: While reset is asserted and right after it, no source is granted: `grant_onehot` is 0, `grant_idx` is 0, `phy_tx_valid` is 0, `phy_tx_data` is 0 and every `src_tx_ready` bit is 0, whatever the sources drive.
- R2: On a clock edge where the current owner is not presenting transmit-valid, the grant after that edge goes to the lowest-indexed source whose `src_active` bit is set. Index 0 wins over all others. If no source is active, no source is granted.
- R3: While source i is granted, `phy_tx_data` equals `src_tx_data[i*8 +: 8]` and `phy_tx_valid` equals `src_tx_valid[i]`, both in the same cycle.
- R4: While no source is granted, `phy_tx_valid` is 0 and `phy_tx_data` is 0.
- R5: `src_tx_ready[i]` equals `phy_tx_ready` when source i is granted. It is 0 for every other source.
- R6: On a clock edge where the granted source has `src_tx_valid` high, the grant is unchanged after that edge. This holds even if a higher-priority source is active, and even if the owner has dropped its own active flag.
- R7: A granted source with both transmit-valid and active low at a clock edge loses the grant after that edge.
- R8: A granted source that is not transmitting is replaced after the next edge by any higher-priority source that is active at that edge.
- R9: `grant_onehot` has at most one bit set. When bit i is set, `grant_idx` equals i. When no bit is set, `grant_idx` is 0.
- R10: The data and valid inputs of sources that are not granted have no effect on `phy_tx_data` or `phy_tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_active | input | 6 | Per-source request to own the transmit path |
| src_tx_valid | input | 6 | Per-source transmit-valid |
| src_tx_data | input | 48 | Per-source transmit byte, source i at bits i*8+7..i*8 |
| src_tx_ready | output | 6 | PHY ready routed to the owner only |
| phy_tx_data | output | 8 | Byte to the PHY |
| phy_tx_valid | output | 1 | Transmit-valid to the PHY |
| phy_tx_ready | input | 1 | Ready from the PHY |
| grant_onehot | output | 6 | One-hot owner vector |
| grant_idx | output | 3 | Encoded owner index |

## Verification
The case hardest to reach is a packet lock that is tested against every way it could break. To get there, a low-priority source must first win the grant while idle, then raise valid. After that, higher-priority sources become active around it, and the owner drops its own active flag while valid stays high. The stimulus table walks through that sequence one edge at a time and checks that the owner is kept. It then checks the cycle where valid falls: the grant must move at once to the top active source. Further steps cover an owner that is idle but not active being released, stray valid from sources without the grant, and a reset applied in the middle of a packet.

// File: rtl/usb_tx_prio_mux.sv
module usb_tx_prio_mux #(
  parameter int N_SRC  = 6,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        src_active,
  input  logic [N_SRC-1:0]        src_tx_valid,
  input  logic [N_SRC*DATA_W-1:0] src_tx_data,
  output logic [N_SRC-1:0]        src_tx_ready,
  output logic [DATA_W-1:0]       phy_tx_data,
  output logic                    phy_tx_valid,
  input  logic                    phy_tx_ready,
  output logic [N_SRC-1:0]        grant_onehot,
  output logic [IDX_W-1:0]        grant_idx
);

  logic [N_SRC-1:0] gnt_q;
  logic [N_SRC-1:0] pick;
  logic             busy;

  always_comb begin
    pick = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (src_active[i]) pick = N_SRC'(1) << i;
  end

  assign busy = |(gnt_q & src_tx_valid);

  always_ff @(posedge clk) begin
    if (!rst_n)    gnt_q <= '0;
    else if (!busy) gnt_q <= pick;
  end

  always_comb begin
    phy_tx_data  = '0;
    phy_tx_valid = 1'b0;
    grant_idx    = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (gnt_q[i]) begin
        phy_tx_data  = src_tx_data[i*DATA_W +: DATA_W];
        phy_tx_valid = src_tx_valid[i];
        grant_idx    = IDX_W'(i);
      end
    end
  end

  assign src_tx_ready = gnt_q & {N_SRC{phy_tx_ready}};
  assign grant_onehot = gnt_q;

endmodule

// File: rtl/usb_tx_prio_mux_chk.sv
module usb_tx_prio_mux_chk #(
  parameter int N_SRC  = 6,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_SRC-1:0]        src_active,
  input logic [N_SRC-1:0]        src_tx_ready,
  input logic [DATA_W-1:0]       phy_tx_data,
  input logic                    phy_tx_valid,
  input logic                    phy_tx_ready,
  input logic [N_SRC-1:0]        grant_onehot,
  input logic [IDX_W-1:0]        grant_idx
);

  logic [N_SRC-1:0] low_act;
  assign low_act = src_active & (~src_active + N_SRC'(1));

  // R2
  top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_tx_valid |=> grant_onehot == $past(low_act));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_onehot == '0 |-> (!phy_tx_valid && phy_tx_data == '0));

  // R5
  ready_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tx_ready & ~grant_onehot) == '0);

  // R5
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_tx_ready) |-> phy_tx_ready);

  // R6
  packet_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_tx_valid |=> grant_onehot == $past(grant_onehot));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_onehot != '0 && !phy_tx_valid && (src_active & grant_onehot) == '0)
      |=> (grant_onehot & $past(grant_onehot)) == '0);

  // R9
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_onehot));

  // R9
  idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_onehot != '0 |-> grant_onehot[grant_idx]);

  // R9
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_onehot == '0 |-> grant_idx == '0);

endmodule

bind usb_tx_prio_mux usb_tx_prio_mux_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .src_active(src_active),
  .src_tx_ready(src_tx_ready), .phy_tx_data(phy_tx_data),
  .phy_tx_valid(phy_tx_valid), .phy_tx_ready(phy_tx_ready),
  .grant_onehot(grant_onehot), .grant_idx(grant_idx)
);

// File: tb/usb_tx_prio_mux_tb_top.sv
`timescale 1ns/1ps
module usb_tx_prio_mux_tb_top;
  localparam int N = 6;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   act = '0, vld = '0;
  logic [N*W-1:0] dat;
  logic           rdy = 1'b0;
  logic [N-1:0]   s_rdy, gnt;
  logic [W-1:0]   p_dat;
  logic           p_vld;
  logic [2:0]     gidx;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  usb_tx_prio_mux dut_i (
    .clk(clk), .rst_n(rst_n), .src_active(act), .src_tx_valid(vld),
    .src_tx_data(dat), .src_tx_ready(s_rdy), .phy_tx_data(p_dat),
    .phy_tx_valid(p_vld), .phy_tx_ready(rdy), .grant_onehot(gnt),
    .grant_idx(gidx)
  );

  // {active, valid, ready, expected grant after the edge}
  localparam logic [18:0] VEC [16] = '{
    {6'b000000, 6'b000000, 1'b0, 6'b000000},
    {6'b100000, 6'b000000, 1'b0, 6'b100000},
    {6'b100100, 6'b000000, 1'b1, 6'b000100},
    {6'b100100, 6'b000100, 1'b1, 6'b000100},
    {6'b100111, 6'b000100, 1'b0, 6'b000100},
    {6'b100011, 6'b000100, 1'b1, 6'b000100},
    {6'b100011, 6'b000000, 1'b1, 6'b000001},
    {6'b100010, 6'b000000, 1'b0, 6'b000010},
    {6'b100010, 6'b100000, 1'b1, 6'b000010},
    {6'b100010, 6'b000010, 1'b1, 6'b000010},
    {6'b000000, 6'b000010, 1'b0, 6'b000010},
    {6'b000000, 6'b000000, 1'b1, 6'b000000},
    {6'b010000, 6'b000000, 1'b0, 6'b010000},
    {6'b011000, 6'b000000, 1'b0, 6'b001000},
    {6'b111111, 6'b111111, 1'b1, 6'b001000},
    {6'b111111, 6'b110111, 1'b1, 6'b000001}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic load_data(input logic [W-1:0] base);
    for (int i = 0; i < N; i++) dat[i*W +: W] = base + W'(i);
  endtask

  task automatic check_route(input logic [N-1:0] eg, input logic [N-1:0] v,
                             input logic r, input logic [W-1:0] base, input string req);
    logic [W-1:0] ed;
    logic [2:0]   ei;
    logic         ev;
    ed = '0; ei = '0; ev = 1'b0;
    for (int i = 0; i < N; i++)
      if (eg[i]) begin ed = base + W'(i); ei = 3'(i); ev = v[i]; end
    chk(gnt == eg, req, "grant_onehot", 64'(gnt), 64'(eg));
    chk(gidx == ei, "R9", "grant_idx", 64'(gidx), 64'(ei));
    chk(p_vld == ev, "R3", "phy_tx_valid", 64'(p_vld), 64'(ev));
    chk(p_dat == ed, (eg == 0) ? "R4" : "R3", "phy_tx_data", 64'(p_dat), 64'(ed));
    chk(s_rdy == (r ? eg : '0), "R5", "src_tx_ready", 64'(s_rdy), 64'(r ? eg : '0));
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    load_data(8'hA0);
    // R1: sources busy during reset, nothing may be granted
    act = '1; vld = '1; rdy = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_route('0, vld, rdy, 8'hA0, "R1");
    @(negedge clk);
    act = '0; vld = '0; rdy = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_route('0, vld, rdy, 8'hA0, "R1");

    // Table walk: R2 R6 R7 R8 R10
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      act = VEC[k][18:13]; vld = VEC[k][12:7]; rdy = VEC[k][6];
      @(posedge clk); #1;
      check_route(VEC[k][5:0], vld, rdy, 8'hA0, "R2/R6/R7/R8");
    end

    // R10: other sources' data and valid change; grant stays on source 0
    @(negedge clk);
    act = 6'b000001; vld = 6'b000000; rdy = 1'b0;
    @(posedge clk); #1;
    check_route(6'b000001, vld, rdy, 8'hA0, "R2");
    @(negedge clk);
    for (int i = 1; i < N; i++) dat[i*W +: W] = 8'h5A ^ W'(i);
    vld = 6'b111110;
    #1;
    chk(p_dat == 8'hA0, "R10", "phy_tx_data", 64'(p_dat), 64'hA0);
    chk(p_vld == 1'b0, "R10", "phy_tx_valid", 64'(p_vld), 64'h0);
    load_data(8'hA0);

    // R8: idle lowest-priority owner preempted by source 3
    @(negedge clk);
    act = 6'b100000; vld = '0;
    @(posedge clk); #1;
    check_route(6'b100000, vld, rdy, 8'hA0, "R2");
    @(negedge clk);
    act = 6'b101000;
    @(posedge clk); #1;
    check_route(6'b001000, vld, rdy, 8'hA0, "R8");

    // R1: reset in the middle of a packet clears the grant
    @(negedge clk);
    vld = 6'b001000; rdy = 1'b1;
    @(posedge clk); #1;
    check_route(6'b001000, vld, rdy, 8'hA0, "R6");
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    check_route('0, vld, rdy, 8'hA0, "R1");
    @(negedge clk);
    rst_n = 1'b1; act = '0; vld = '0;
    @(posedge clk); #1;
    check_route('0, vld, rdy, 8'hA0, "R4");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule